// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block runs an 8-bit successive-approximation conversion on one of eight analog inputs. A one-cycle start request, accepted only while the block is idle, captures the channel number and the clock-rate choice, drives the channel number to the external analog multiplexer and holds a sample-enable high while the input is acquired. It then walks the code from the most significant bit down to the least significant bit. For each bit it presents a trial code to an external DAC and reads back one comparator bit.

When the last trial is over, the block copies the finished code into the result register, raises a done flag that stays high until the next accepted start, and pulses an interrupt for one cycle. The conversion clock is not a separate clock. It is an enable made from the system clock, either on every cycle or on every second cycle. A conversion always spans 160 conversion-clock periods. The first 12 are spent sampling, each bit trial takes 18, and the last 4 settle the result.

Top module: `sar_adc_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle: `busy_o`, `sample_o`, `done_o` and `irq_o` are 0 and `result_o` is 00h. This also applies in the middle of a conversion.
- R2: A start accepted in idle keeps `busy_o` high for exactly 160 conversion-clock periods, counted from the edge that accepts the start.
- R3: `div2_i` is sampled with the start. When it is 0 a conversion-clock period is one system cycle, and when it is 1 it is two system cycles. Changing `div2_i` during a conversion has no effect.
- R4: `chan_i` is captured when a start is accepted and is driven on `chan_sel_o` without change for the whole conversion, whatever `chan_i` does afterwards.
- R5: `sample_o` is high for exactly the first 12 conversion-clock periods of a conversion and is low at all other times.
- R6: Bit trials run from bit 7 down to bit 0 and each lasts 18 conversion-clock periods. At the start of trial k (k = 0 for bit 7), `trial_o` holds the bits already decided, with bit 7-k set and the lower bits clear. `cmp_above_i` is sampled on the last conversion clock of a trial. A 1 (input at or above the trial level) keeps the bit, and a 0 clears it.
- R7: With an ideal comparator, `result_o` equals the input code after the conversion. `result_o` changes only on the edge that ends a conversion.
- R8: `done_o` rises on the edge that ends a conversion, is low for the whole conversion, and stays high until the next accepted start clears it.
- R9: `irq_o` is high for exactly one cycle, the first cycle in which `done_o` is high.
- R10: A start request while `busy_o` is high is ignored. The conversion length, the channel and the result of the running conversion are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only in idle |
| chan_i | input | 3 | Channel to convert |
| div2_i | input | 1 | 1: conversion clock at half the system rate |
| cmp_above_i | input | 1 | Comparator: 1 when the input is at or above the trial level |
| chan_sel_o | output | 3 | Channel select to the analog multiplexer |
| sample_o | output | 1 | Sample-enable to the input switch |
| trial_o | output | 8 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Conversion finished, held until the next start |
| result_o | output | 8 | Last completed conversion result |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
Let D be 1 or 2 depending on the prescaler. All timing is counted from the edge that accepts the start. The sample window closes after 12·D cycles, trial k begins 12·D + 18·k·D cycles in, and `busy_o` falls together with the rise of `done_o`, `irq_o` and the new result at 160·D cycles. The bench samples every output on the falling edge. It keeps a cycle count from the accepting edge and compares `trial_o` exactly at each trial boundary. It checks the busy and sample lengths against 160·D and 12·D, and it checks the result and flags in the first cycle after busy ends and again one cycle later.

// File: rtl/sar_adc_pkg.sv
// Shared types for the successive-approximation sequencer.
// Assumes nothing beyond a single clock domain.
package sar_adc_pkg;

    // Conversion phase, in the order a conversion passes through them.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2,
        PH_FINISH = 2'd3
    } sar_phase_e;

    // Largest of three phase lengths; sizes the shared phase counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sar_prescale.sv
// Conversion-clock enable generator.
// Makes a one-cycle tick per conversion-clock period. The tick comes on every
// system cycle, or on every second cycle when the divide option was selected
// at start. The divide choice and the phase restart with each accepted start.
// Assumes start_acc and busy come from the same clock domain.
module sar_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc,
    input  logic busy,
    input  logic div2_i,
    output logic tick
);

    logic div2_q;
    logic half_q;

    // Capture the rate choice when a conversion starts.
    always_ff @(posedge clk) begin
        if (!rst_n)         div2_q <= 1'b0;
        else if (start_acc) div2_q <= div2_i;
    end

    // Alternate phase while busy; restart at start.
    always_ff @(posedge clk) begin
        if (!rst_n)         half_q <= 1'b0;
        else if (start_acc) half_q <= 1'b0;
        else if (busy)      half_q <= ~half_q;
    end

    // Tick on every busy cycle, or on the odd half in divide mode.
    always_comb tick = busy && (!div2_q || half_q);

    // R3
    div2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div2_q && tick && !start_acc) |=> !tick);

endmodule

// File: rtl/sar_seq_ctrl.sv
// Phase sequencer for one conversion.
// Counts conversion-clock ticks through the sample window, RES_BITS bit
// trials and a closing settle window. It emits one-cycle strobes when the
// first trial begins, when a trial ends and when the conversion ends.
// Assumes tick is only high while a conversion runs.
module sar_seq_ctrl
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS    = 8,
    parameter int SAMPLE_CLKS = 12,
    parameter int TRIAL_CLKS  = 18,
    parameter int TAIL_CLKS   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_acc,
    input  logic                        tick,
    output sar_phase_e                  phase_o,
    output logic [$clog2(RES_BITS)-1:0] bit_idx_o,
    output logic                        enter_trial_o,
    output logic                        trial_end_o,
    output logic                        conv_end_o
);

    localparam int CNT_MAX = max3(SAMPLE_CLKS, TRIAL_CLKS, TAIL_CLKS);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int IDX_W   = $clog2(RES_BITS);

    sar_phase_e        phase_q;
    logic [CNT_W-1:0]  sub_q;
    logic [CNT_W-1:0]  sub_lim;
    logic [IDX_W-1:0]  idx_q;
    logic              at_last;

    // Last count value of the current phase.
    always_comb begin
        case (phase_q)
            PH_SAMPLE: sub_lim = CNT_W'(SAMPLE_CLKS - 1);
            PH_TRIAL:  sub_lim = CNT_W'(TRIAL_CLKS - 1);
            PH_FINISH: sub_lim = CNT_W'(TAIL_CLKS - 1);
            default:   sub_lim = '0;
        endcase
    end

    // Phase boundary strobes.
    always_comb begin
        at_last       = (sub_q == sub_lim);
        enter_trial_o = tick && at_last && (phase_q == PH_SAMPLE);
        trial_end_o   = tick && at_last && (phase_q == PH_TRIAL);
        conv_end_o    = tick && at_last && (phase_q == PH_FINISH);
    end

    // Advance phase, in-phase count and bit index on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sub_q   <= '0;
            idx_q   <= '0;
        end else if (start_acc) begin
            phase_q <= PH_SAMPLE;
            sub_q   <= '0;
            idx_q   <= '0;
        end else if (tick && phase_q != PH_IDLE) begin
            if (at_last) begin
                sub_q <= '0;
                case (phase_q)
                    PH_SAMPLE: begin
                        phase_q <= PH_TRIAL;
                        idx_q   <= IDX_W'(RES_BITS - 1);
                    end
                    PH_TRIAL: begin
                        if (idx_q == '0) phase_q <= PH_FINISH;
                        else             idx_q   <= idx_q - 1'b1;
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign phase_o   = phase_q;
    assign bit_idx_o = idx_q;

    // R6
    first_trial_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_trial_o |=> (phase_o == PH_TRIAL && bit_idx_o == IDX_W'(RES_BITS - 1)));

    // R6
    trial_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_end_o && bit_idx_o != '0) |=> (bit_idx_o == $past(bit_idx_o) - 1'b1));

endmodule

// File: rtl/sar_approx_reg.sv
// Successive-approximation register and result store.
// Each bit has its own update slice. A bit is set when its trial begins and
// is kept or cleared from the comparator when that trial ends. The result
// copies the register only when the conversion ends.
// Assumes the strobes from sar_seq_ctrl never overlap.
module sar_approx_reg #(
    parameter int RES_BITS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_acc,
    input  logic                        enter_trial,
    input  logic                        trial_end,
    input  logic                        conv_end,
    input  logic [$clog2(RES_BITS)-1:0] bit_idx,
    input  logic                        cmp_above,
    output logic [RES_BITS-1:0]         trial_code_o,
    output logic [RES_BITS-1:0]         result_o
);

    logic [RES_BITS-1:0] code_q;
    logic [RES_BITS-1:0] res_q;

    for (genvar b = 0; b < RES_BITS; b++) begin : g_bit
        // Set when this bit's trial opens, decide when it closes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q[b] <= 1'b0;
            else if (start_acc)
                code_q[b] <= 1'b0;
            else if (enter_trial && b == RES_BITS - 1)
                code_q[b] <= 1'b1;
            else if (trial_end && int'(bit_idx) == b)
                code_q[b] <= cmp_above;
            else if (trial_end && int'(bit_idx) == b + 1)
                code_q[b] <= 1'b1;
        end
    end

    // Result is written only on the conversion-end strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        res_q <= '0;
        else if (conv_end) res_q <= code_q;
    end

    assign trial_code_o = code_q;
    assign result_o     = res_q;

    // R6
    keep_on_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_end && cmp_above) |=> code_q[$past(bit_idx)]);

    // R6
    drop_on_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_end && !cmp_above) |=> !code_q[$past(bit_idx)]);

endmodule

// File: rtl/sar_adc_seq.sv
// Top of the successive-approximation conversion sequencer.
// Accepts a start only in idle, captures the channel and drives the analog
// mux, sample switch and trial DAC. It runs the fixed-length conversion and
// reports completion with a held done flag and a one-cycle interrupt.
// Assumes the comparator output is valid by the last tick of each trial.
module sar_adc_seq
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS    = 8,
    parameter int CHAN_COUNT  = 8,
    parameter int SAMPLE_CLKS = 12,
    parameter int TRIAL_CLKS  = 18,
    parameter int TAIL_CLKS   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [$clog2(CHAN_COUNT)-1:0] chan_i,
    input  logic                          div2_i,
    input  logic                          cmp_above_i,
    output logic [$clog2(CHAN_COUNT)-1:0] chan_sel_o,
    output logic                          sample_o,
    output logic [RES_BITS-1:0]           trial_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic [RES_BITS-1:0]           result_o,
    output logic                          irq_o
);

    localparam int CH_W  = $clog2(CHAN_COUNT);
    localparam int IDX_W = $clog2(RES_BITS);

    sar_phase_e        phase;
    logic [IDX_W-1:0]  bit_idx;
    logic              tick;
    logic              start_acc;
    logic              enter_trial;
    logic              trial_end;
    logic              conv_end;
    logic [CH_W-1:0]   chan_q;
    logic              done_q;
    logic              irq_q;

    // A start counts only while idle.
    always_comb begin
        busy_o    = (phase != PH_IDLE);
        start_acc = start_i && !busy_o;
        sample_o  = (phase == PH_SAMPLE);
    end

    // Capture the channel for the whole conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)         chan_q <= '0;
        else if (start_acc) chan_q <= chan_i;
    end

    // Done flag: set at completion, cleared by the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_q <= 1'b0;
        else if (start_acc) done_q <= 1'b0;
        else if (conv_end)  done_q <= 1'b1;
    end

    // Single-cycle completion interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= conv_end;
    end

    sar_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .busy      (busy_o),
        .div2_i    (div2_i),
        .tick      (tick)
    );

    sar_seq_ctrl #(
        .RES_BITS    (RES_BITS),
        .SAMPLE_CLKS (SAMPLE_CLKS),
        .TRIAL_CLKS  (TRIAL_CLKS),
        .TAIL_CLKS   (TAIL_CLKS)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_acc     (start_acc),
        .tick          (tick),
        .phase_o       (phase),
        .bit_idx_o     (bit_idx),
        .enter_trial_o (enter_trial),
        .trial_end_o   (trial_end),
        .conv_end_o    (conv_end)
    );

    sar_approx_reg #(
        .RES_BITS (RES_BITS)
    ) u_sar (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_acc    (start_acc),
        .enter_trial  (enter_trial),
        .trial_end    (trial_end),
        .conv_end     (conv_end),
        .bit_idx      (bit_idx),
        .cmp_above    (cmp_above_i),
        .trial_code_o (trial_o),
        .result_o     (result_o)
    );

    assign chan_sel_o = chan_q;
    assign done_o     = done_q;
    assign irq_o      = irq_q;

    // R4
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !conv_end) |=> $stable(chan_sel_o));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !conv_end) |=> busy_o);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (irq_o || $stable(result_o)));

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    // R9
    irq_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R9
    irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $rose(done_o));

    // R5
    sample_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> busy_o);

endmodule

// File: tb/sim_sar_adc_seq.sv
// Bench: ideal comparator against a chosen code; every code swept at full
// rate, a set of codes at half rate, ignored starts and a mid-run reset.
module sim_sar_adc_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [2:0] chan;
    logic       div2;
    logic [7:0] vin;
    logic [2:0] chan_sel;
    logic       sample;
    logic [7:0] trial;
    logic       busy;
    logic       done;
    logic [7:0] result;
    logic       irq;
    logic       cmp;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    assign cmp = (vin >= trial);

    sar_adc_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .chan_i      (chan),
        .div2_i      (div2),
        .cmp_above_i (cmp),
        .chan_sel_o  (chan_sel),
        .sample_o    (sample),
        .trial_o     (trial),
        .busy_o      (busy),
        .done_o      (done),
        .result_o    (result),
        .irq_o       (irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(1'b0, "watchdog", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // One conversion; poke = extra start request while busy (R10).
    task automatic convert(input int code, input int ch, input bit d2, input bit poke);
        int n = 0;
        int samp = 0;
        int chan_bad = 0;
        int trial_bad = 0;
        int flag_bad = 0;
        int res_bad = 0;
        int d;
        int prev;
        int exp_code;
        d    = d2 ? 2 : 1;
        prev = result;
        vin  = 8'(code);
        @(negedge clk);
        start = 1'b1;
        chan  = 3'(ch);
        div2  = d2;
        @(negedge clk);
        start = 1'b0;
        chan  = chan ^ 3'b111;
        div2  = ~d2;
        chk(done == 1'b0, "R8 done cleared by start", done, 0);
        while (busy && n < 1000) begin
            if (sample) samp++;
            if (chan_sel != 3'(ch)) chan_bad++;
            if (done || irq) flag_bad++;
            if (int'(result) != prev) res_bad++;
            for (int k = 0; k < 8; k++) begin
                if (n == (12 + 18 * k) * d) begin
                    exp_code = ((code >> (8 - k)) << (8 - k)) | (1 << (7 - k));
                    if (int'(trial) != exp_code) trial_bad++;
                end
            end
            if (poke && n == 40) begin
                start = 1'b1;
                chan  = 3'(ch) ^ 3'b011;
            end
            if (poke && n == 41) start = 1'b0;
            n++;
            @(negedge clk);
        end
        chk(n == 160 * d, "R2 busy length", n, 160 * d);
        chk(n == 160 * d, "R3 prescaler ratio", n / 160, d);
        chk(samp == 12 * d, "R5 sample window", samp, 12 * d);
        chk(sample == 1'b0, "R5 sample low after", sample, 0);
        chk(chan_bad == 0, "R4 channel held", chan_bad, 0);
        chk(trial_bad == 0, "R6 trial codes", trial_bad, 0);
        chk(flag_bad == 0, "R8 flags low while busy", flag_bad, 0);
        chk(res_bad == 0, "R7 result held while busy", res_bad, 0);
        chk(int'(result) == code, "R7 result value", result, code);
        chk(done == 1'b1, "R8 done at end", done, 1);
        chk(irq == 1'b1, "R9 irq at end", irq, 1);
        if (poke)
            chk(n == 160 * d && chan_bad == 0 && int'(result) == code,
                "R10 busy start ignored", result, code);
        @(negedge clk);
        chk(irq == 1'b0, "R9 irq single cycle", irq, 0);
        chk(done == 1'b1, "R8 done held", done, 1);
        chk(int'(result) == code, "R7 result kept", result, code);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        chan  = '0;
        div2  = 1'b0;
        vin   = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && sample == 1'b0, "R1 reset idle", busy, 0);
        chk(done == 1'b0 && irq == 1'b0, "R1 reset flags", done, 0);
        chk(result == 8'h00, "R1 reset result", result, 0);
        rst_n = 1'b1;

        for (int c = 0; c < 256; c++)
            convert(c, c % 8, 1'b0, (c % 37) == 5);

        convert(0,    3, 1'b1, 1'b0);
        convert(255,  6, 1'b1, 1'b0);
        convert(8'hA5, 1, 1'b1, 1'b1);
        convert(8'h5A, 7, 1'b1, 1'b0);
        convert(1,    2, 1'b1, 1'b0);
        convert(128,  5, 1'b1, 1'b0);

        // R1 reset in the middle of a conversion
        vin = 8'h3C;
        @(negedge clk);
        start = 1'b1;
        chan  = 3'd4;
        div2  = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && sample == 1'b0, "R1 mid-run reset idle", busy, 0);
        chk(result == 8'h00, "R1 mid-run reset result", result, 0);
        chk(done == 1'b0 && irq == 1'b0, "R1 mid-run reset flags", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule